// File: doc/BRIEF.md
# Composite Video Output Formatter

This block builds the 8-bit composite video word stream that leaves a line-locked video digitizer. It runs on the 2x pixel clock and makes its own half-rate data strobe. Each new pixel is captured on alternate clocks and held for two clocks, so it changes only when the strobe rises. An optional digital clamp moves every converter sample so that the measured back-porch level lands on a fixed code for the selected standard. During the sync tip with the clamp on, a programmable sync code is sent in place of the sample.

At the start of each horizontal sync tip the block can send a genlock reference on the low four bits at the full clock rate. The reference is thirteen nibbles long: a field-identifier nibble, then the 24-bit subcarrier frequency word, then the 24-bit subcarrier phase word. When line lock is lost, fixed default frequency and phase words replace the measured ones, and video can be forced to zero. A bus-enable control drives an output-enable signal that the pad ring uses to tri-state the data bus and both sync pins.

Top module: `cvbs_formatter`

## Requirements
- R1: While `rst_n` is low and at the first sample after reset, `cvbs_o` is 00h, `bus_oe` is 0, `ldv_o` is 0, and `hsync_n_o` and `vsync_n_o` are 1.
- R2: `ldv_o` inverts on every clock. A new video word reaches `cvbs_o` only on the edge where `ldv_o` goes from 0 to 1, and it holds through the edge where `ldv_o` falls.
- R3: With `clamp_en`=1 and `sync_tip`=0, the video word is `adc_sample - blank_level + T`, limited to the range 00h..FFh. T is 3Ch when `pal_mode`=0 and 40h when `pal_mode`=1.
- R4: With `clamp_en`=0, the video word is `adc_sample` unchanged, including while `sync_tip` is high.
- R5: With `clamp_en`=1 and `sync_tip`=1, the video word is `sync_tip_lvl` plus 0 when `pal_mode`=0, or plus 4 when `pal_mode`=1. The default setting of 3h therefore gives 03h or 07h.
- R6: On the clock edge after `sync_tip` rises, and on the twelve edges that follow while it stays high, `cvbs_o` is {0000b, nibble k} with k=0..12. Nibble 0 is the field nibble. Nibbles 1..6 are the frequency word bits 23:20, 19:16, and so on down to 3:0. Nibbles 7..12 are the phase word in the same order.
- R7: Field nibble bit 3 is the inverse of `line_inv` (1 on lines with the uninverted burst). With `pal_mode`=0, bits 2:0 are {0, field_cnt[1:0]}. With `pal_mode`=1, bits 2:0 are `field_cnt[2:0]`. `field_cnt` is 0 for field 1, so bit 0 is 0 for odd fields.
- R8: With `burst_dis`=1, no reference nibbles are sent, and the sync level of R5 stays on the bus through the sync tip.
- R9: With `locked`=0, the frequency and phase nibbles come from 2A098Bh and 1C71C7h when `pal_mode`=0, or from 2A8A6Ch and 0E38E4h when `pal_mode`=1.
- R10: With `locked`=0 and `grs_only`=1, every video word, sync level included, is 00h. Reference nibbles are still sent.
- R11: `bus_oe` equals `bus_en` delayed by one clock.
- R12: `hsync_n_o` and `vsync_n_o` equal `hsync_n_in` and `vsync_n_in` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2x pixel clock |
| rst_n | input | 1 | Active-low reset |
| adc_sample | input | 8 | Converter sample |
| blank_level | input | 8 | Measured back-porch level |
| clamp_en | input | 1 | Digital clamp enable |
| sync_tip_lvl | input | 4 | Sync code base value |
| pal_mode | input | 1 | 1 selects PAL, 0 selects NTSC |
| sync_tip | input | 1 | High during the horizontal sync tip |
| hsync_n_in | input | 1 | Horizontal sync, active low |
| vsync_n_in | input | 1 | Vertical sync, active low |
| field_cnt | input | 3 | Field number minus one |
| line_inv | input | 1 | 1 on lines with the inverted burst |
| freq_word | input | 24 | Measured subcarrier frequency |
| phase_word | input | 24 | Measured subcarrier phase |
| locked | input | 1 | Line lock present |
| grs_only | input | 1 | Zero video while unlocked |
| burst_dis | input | 1 | Suppress reference nibbles |
| bus_en | input | 1 | Output bus enable |
| cvbs_o | output | 8 | Composite data word |
| bus_oe | output | 1 | Drive enable for data and sync pads |
| ldv_o | output | 1 | Half-rate data strobe |
| hsync_n_o | output | 1 | Registered horizontal sync |
| vsync_n_o | output | 1 | Registered vertical sync |

## Verification
The clamp is swept over every sample code against blank levels at 00h, the two target codes, mid-scale and FFh, for both standards. This finds a design that wraps instead of limiting, or that uses the wrong target code. All 32 combinations of field count, standard and burst inversion go through a full reference burst. A wrong nibble order, a wrong field mask or a one-clock offset shows up as a mismatch on a named nibble. Unlocked runs with and without zero forcing check that the default words replace the measured ones and that zero forcing does not blank the reference. The bench changes a sample while the strobe is high to confirm that a pixel is held for two clocks.

// File: rtl/cvbs_fmt_pkg.sv
package cvbs_fmt_pkg;
    localparam int PIX_W  = 8;
    localparam int NIB_W  = 4;
    localparam int WORD_W = 24;
    localparam int NIBS_PER_WORD = WORD_W / NIB_W;
    localparam int BURST_LEN = 1 + 2 * NIBS_PER_WORD;
    localparam int CNT_W = $clog2(BURST_LEN + 1);

    typedef struct packed {
        logic             phase;
        logic [PIX_W-1:0] pix;
        logic [PIX_W-1:0] out;
        logic             oe;
        logic             hs;
        logic             vs;
    } fmt_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tip_prev;
    } seq_state_t;
endpackage

// File: rtl/cvbs_level.sv
module cvbs_level
    import cvbs_fmt_pkg::*;
#(
    parameter logic [PIX_W-1:0] NTSC_TARGET = 8'h3C,
    parameter logic [PIX_W-1:0] PAL_TARGET  = 8'h40,
    parameter logic [PIX_W-1:0] PAL_SYNC_UP = 8'h04
) (
    input  logic [PIX_W-1:0] sample,
    input  logic [PIX_W-1:0] blank,
    input  logic             clamp_en,
    input  logic             pal,
    input  logic             tip,
    input  logic [NIB_W-1:0] tip_lvl,
    input  logic             force_zero,
    output logic [PIX_W-1:0] level
);
    localparam int EXT_W = PIX_W + 2;

    logic signed [EXT_W-1:0] sum;
    logic [PIX_W-1:0]        target;

    always_comb begin
        target = pal ? PAL_TARGET : NTSC_TARGET;
        sum = $signed({2'b00, sample}) - $signed({2'b00, blank})
            + $signed({2'b00, target});
        if (force_zero) begin
            level = '0;
        end else if (!clamp_en) begin
            level = sample;
        end else if (tip) begin
            level = PIX_W'(tip_lvl) + (pal ? PAL_SYNC_UP : '0);
        end else if (sum < 0) begin
            level = '0;
        end else if (sum > $signed(EXT_W'({PIX_W{1'b1}}))) begin
            level = '1;
        end else begin
            level = sum[PIX_W-1:0];
        end
    end
endmodule

// File: rtl/cvbs_grs_seq.sv
module cvbs_grs_seq
    import cvbs_fmt_pkg::*;
#(
    parameter logic [WORD_W-1:0] DEF_FREQ_NTSC  = 24'h2A098B,
    parameter logic [WORD_W-1:0] DEF_PHASE_NTSC = 24'h1C71C7,
    parameter logic [WORD_W-1:0] DEF_FREQ_PAL   = 24'h2A8A6C,
    parameter logic [WORD_W-1:0] DEF_PHASE_PAL  = 24'h0E38E4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tip,
    input  logic              burst_dis,
    input  logic              pal,
    input  logic              locked,
    input  logic              line_inv,
    input  logic [2:0]        field_cnt,
    input  logic [WORD_W-1:0] freq_word,
    input  logic [WORD_W-1:0] phase_word,
    output logic              ref_act,
    output logic [NIB_W-1:0]  ref_nib
);
    seq_state_t s_d, s_q;
    logic              start;
    logic [CNT_W-1:0]  idx;
    logic [WORD_W-1:0] fw, pw;
    logic [NIB_W-1:0]  field_nib;
    int                sh;

    always_comb begin
        s_d        = s_q;
        s_d.tip_prev = tip;
        start      = tip && !s_q.tip_prev;
        fw = locked ? freq_word  : (pal ? DEF_FREQ_PAL  : DEF_FREQ_NTSC);
        pw = locked ? phase_word : (pal ? DEF_PHASE_PAL : DEF_PHASE_NTSC);
        field_nib = {~line_inv, pal ? field_cnt : {1'b0, field_cnt[1:0]}};

        if (start)
            s_d.cnt = CNT_W'(1);
        else if (s_q.cnt != '0 && tip && s_q.cnt < CNT_W'(BURST_LEN - 1))
            s_d.cnt = s_q.cnt + CNT_W'(1);
        else
            s_d.cnt = '0;

        idx     = start ? '0 : s_q.cnt;
        ref_act = !burst_dis && (start || (s_q.cnt != '0 && tip));
        sh      = 0;
        if (idx == '0) begin
            ref_nib = field_nib;
        end else if (idx <= CNT_W'(NIBS_PER_WORD)) begin
            sh      = NIB_W * (NIBS_PER_WORD - int'(idx));
            ref_nib = NIB_W'(fw >> sh);
        end else begin
            sh      = NIB_W * (2 * NIBS_PER_WORD - int'(idx));
            ref_nib = NIB_W'(pw >> sh);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cvbs_formatter.sv
module cvbs_formatter
    import cvbs_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        adc_sample,
    input  logic [7:0]        blank_level,
    input  logic              clamp_en,
    input  logic [3:0]        sync_tip_lvl,
    input  logic              pal_mode,
    input  logic              sync_tip,
    input  logic              hsync_n_in,
    input  logic              vsync_n_in,
    input  logic [2:0]        field_cnt,
    input  logic              line_inv,
    input  logic [23:0]       freq_word,
    input  logic [23:0]       phase_word,
    input  logic              locked,
    input  logic              grs_only,
    input  logic              burst_dis,
    input  logic              bus_en,
    output logic [7:0]        cvbs_o,
    output logic              bus_oe,
    output logic              ldv_o,
    output logic              hsync_n_o,
    output logic              vsync_n_o
);
    fmt_state_t      st_d, st_q;
    logic [PIX_W-1:0] level;
    logic             ref_act;
    logic [NIB_W-1:0] ref_nib;

    cvbs_level u_level (
        .sample     (adc_sample),
        .blank      (blank_level),
        .clamp_en   (clamp_en),
        .pal        (pal_mode),
        .tip        (sync_tip),
        .tip_lvl    (sync_tip_lvl),
        .force_zero (!locked && grs_only),
        .level      (level)
    );

    cvbs_grs_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tip        (sync_tip),
        .burst_dis  (burst_dis),
        .pal        (pal_mode),
        .locked     (locked),
        .line_inv   (line_inv),
        .field_cnt  (field_cnt),
        .freq_word  (freq_word),
        .phase_word (phase_word),
        .ref_act    (ref_act),
        .ref_nib    (ref_nib)
    );

    always_comb begin
        st_d       = st_q;
        st_d.phase = ~st_q.phase;
        st_d.pix   = st_q.phase ? st_q.pix : level;
        st_d.out   = ref_act ? {{(PIX_W-NIB_W){1'b0}}, ref_nib} : st_d.pix;
        st_d.oe    = bus_en;
        st_d.hs    = hsync_n_in;
        st_d.vs    = vsync_n_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.hs    <= 1'b1;
            st_q.vs    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cvbs_o    = st_q.out;
    assign bus_oe    = st_q.oe;
    assign ldv_o     = st_q.phase;
    assign hsync_n_o = st_q.hs;
    assign vsync_n_o = st_q.vs;
endmodule

// File: rtl/cvbs_formatter_chk.sv
module cvbs_formatter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_en,
    input logic       bus_oe,
    input logic       ldv_o,
    input logic       hsync_n_in,
    input logic       hsync_n_o,
    input logic       vsync_n_in,
    input logic       vsync_n_o,
    input logic       ref_act,
    input logic [7:0] cvbs_o
);
    p_strobe_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ldv_o != $past(ldv_o));

    p_pixel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ldv_o && !ref_act && !$past(ref_act)) |=> $stable(cvbs_o));

    p_ref_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_act |=> cvbs_o[7:4] == 4'h0);

    p_oe_delay_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> bus_oe == $past(bus_en));

    p_hsync_delay_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> hsync_n_o == $past(hsync_n_in));

    p_vsync_delay_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> vsync_n_o == $past(vsync_n_in));
endmodule

bind cvbs_formatter cvbs_formatter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_oe     (bus_oe),
    .ldv_o      (ldv_o),
    .hsync_n_in (hsync_n_in),
    .hsync_n_o  (hsync_n_o),
    .vsync_n_in (vsync_n_in),
    .vsync_n_o  (vsync_n_o),
    .ref_act    (ref_act),
    .cvbs_o     (cvbs_o)
);

// File: tb/cvbs_formatter_bench.sv
module cvbs_formatter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  adc_sample = '0, blank_level = '0;
    logic        clamp_en = 1'b0, pal_mode = 1'b0, sync_tip = 1'b0;
    logic [3:0]  sync_tip_lvl = 4'h3;
    logic        hsync_n_in = 1'b1, vsync_n_in = 1'b1, line_inv = 1'b0;
    logic [2:0]  field_cnt = '0;
    logic [23:0] freq_word = 24'h123456, phase_word = 24'h9ABCDE;
    logic        locked = 1'b1, grs_only = 1'b0, burst_dis = 1'b0, bus_en = 1'b0;
    logic [7:0]  cvbs_o;
    logic        bus_oe, ldv_o, hsync_n_o, vsync_n_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    cvbs_formatter u_cvbs_formatter (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int clamp_exp(int s, int b, bit pal);
        int v = s - b + (pal ? 'h40 : 'h3C);
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        return v;
    endfunction

    function automatic logic [3:0] nib_exp(int k, logic [3:0] fnib, logic [23:0] f, logic [23:0] p);
        if (k == 0) return fnib;
        if (k <= 6) return f[4*(6-k) +: 4];
        return p[4*(12-k) +: 4];
    endfunction

    task automatic video(input int s, input int exp, input string tag);
        @(negedge clk);
        adc_sample = 8'(s);
        repeat (2) @(negedge clk);
        check(cvbs_o == 8'(exp), tag, cvbs_o, exp);
    endtask

    task automatic burst(input logic [3:0] fnib, input logic [23:0] f, input logic [23:0] p,
                         input bit dis, input int lvl, input string tag);
        @(negedge clk);
        sync_tip = 1'b0;
        repeat (3) @(negedge clk);
        sync_tip = 1'b1;
        for (int k = 0; k < 13; k++) begin
            @(negedge clk);
            if (!dis) begin
                check(cvbs_o == {4'h0, nib_exp(k, fnib, f, p)}, tag, cvbs_o,
                      {4'h0, nib_exp(k, fnib, f, p)});
            end else if (k >= 2) begin
                check(cvbs_o == 8'(lvl), tag, cvbs_o, lvl);
            end
        end
        @(negedge clk);
        check(cvbs_o == 8'(lvl), {tag, " after"}, cvbs_o, lvl);
        sync_tip = 1'b0;
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(cvbs_o == 8'h00 && bus_oe == 1'b0 && ldv_o == 1'b0 && hsync_n_o && vsync_n_o,
              "R1 reset", {cvbs_o, bus_oe, ldv_o, hsync_n_o, vsync_n_o}, 'h0003);
        rst_n = 1'b1;
        @(negedge clk);
        check(cvbs_o == 8'h00 && bus_oe == 1'b0, "R1 after release", cvbs_o, 0);

        // R11 enable path
        bus_en = 1'b1;
        @(negedge clk);
        check(bus_oe == 1'b1, "R11 oe on", bus_oe, 1);
        bus_en = 1'b0;
        @(negedge clk);
        check(bus_oe == 1'b0, "R11 oe off", bus_oe, 0);
        bus_en = 1'b1;

        // R12 sync passthrough
        hsync_n_in = 1'b0; vsync_n_in = 1'b1;
        @(negedge clk);
        check(hsync_n_o == 1'b0 && vsync_n_o == 1'b1, "R12 h low", {hsync_n_o, vsync_n_o}, 1);
        hsync_n_in = 1'b1; vsync_n_in = 1'b0;
        @(negedge clk);
        check(hsync_n_o == 1'b1 && vsync_n_o == 1'b0, "R12 v low", {hsync_n_o, vsync_n_o}, 2);
        vsync_n_in = 1'b1;

        // R4 raw sweep, also during sync tip
        clamp_en = 1'b0;
        for (int s = 0; s < 256; s++) video(s, s, "R4 raw");
        sync_tip = 1'b1; burst_dis = 1'b1;
        video(8'hA5, 8'hA5, "R4 raw in tip");
        sync_tip = 1'b0; burst_dis = 1'b0;

        // R3 clamp sweep
        clamp_en = 1'b1;
        for (int pm = 0; pm < 2; pm++) begin
            pal_mode = pm[0];
            for (int bi = 0; bi < 5; bi++) begin
                int bl;
                case (bi)
                    0: bl = 'h00; 1: bl = 'h3C; 2: bl = 'h40; 3: bl = 'h80; default: bl = 'hFF;
                endcase
                blank_level = 8'(bl);
                for (int s = 0; s < 256; s++)
                    video(s, clamp_exp(s, bl, pm[0]), "R3 clamp");
            end
        end

        // R2 pixel hold over two clocks
        pal_mode = 1'b0; clamp_en = 1'b0;
        video(8'h11, 8'h11, "R2 setup");
        while (ldv_o != 1'b1) @(negedge clk);
        adc_sample = 8'h77;
        @(negedge clk);
        check(cvbs_o == 8'h11 && ldv_o == 1'b0, "R2 hold", cvbs_o, 8'h11);
        @(negedge clk);
        check(cvbs_o == 8'h77 && ldv_o == 1'b1, "R2 update", cvbs_o, 8'h77);

        // R5 sync level sweep
        clamp_en = 1'b1; burst_dis = 1'b1; sync_tip = 1'b1;
        for (int pm = 0; pm < 2; pm++) begin
            pal_mode = pm[0];
            for (int l = 0; l < 16; l++) begin
                sync_tip_lvl = 4'(l);
                video(8'h20, l + (pm ? 4 : 0), "R5 sync level");
            end
        end
        sync_tip = 1'b0; burst_dis = 1'b0; sync_tip_lvl = 4'h3;

        // R6 R7 reference bursts, locked
        for (int pm = 0; pm < 2; pm++) begin
            for (int fc = 0; fc < 8; fc++) begin
                for (int li = 0; li < 2; li++) begin
                    logic [3:0] fn;
                    pal_mode = pm[0]; field_cnt = 3'(fc); line_inv = li[0];
                    fn = {~li[0], pm[0] ? 3'(fc) : {1'b0, 2'(fc)}};
                    freq_word  = 24'h0F1E2D ^ 24'(fc * 24'h111111);
                    phase_word = 24'hC3B4A5 + 24'(li * 24'h010203);
                    burst(fn, freq_word, phase_word, 1'b0, pm ? 7 : 3, "R6 R7 burst");
                end
            end
        end

        // R8 burst disabled
        pal_mode = 1'b0; field_cnt = 3'd1; line_inv = 1'b0; burst_dis = 1'b1;
        burst(4'h0, 24'h0, 24'h0, 1'b1, 3, "R8 no burst");
        pal_mode = 1'b1;
        burst(4'h0, 24'h0, 24'h0, 1'b1, 7, "R8 no burst pal");
        burst_dis = 1'b0;

        // R9 R10 unlocked, video forced to zero
        locked = 1'b0; grs_only = 1'b1;
        pal_mode = 1'b0; field_cnt = 3'd2;
        video(8'h90, 0, "R10 zero video");
        burst(4'hA, 24'h2A098B, 24'h1C71C7, 1'b0, 0, "R9 R10 ntsc defaults");
        pal_mode = 1'b1; field_cnt = 3'd5;
        burst(4'hD, 24'h2A8A6C, 24'h0E38E4, 1'b0, 0, "R9 R10 pal defaults");

        // R9 unlocked without forcing: video passes
        grs_only = 1'b0; clamp_en = 1'b0;
        video(8'h90, 8'h90, "R10 off video passes");
        clamp_en = 1'b1;
        burst(4'hD, 24'h2A8A6C, 24'h0E38E4, 1'b0, 7, "R9 pal defaults");
        locked = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule